// File: doc/BRIEF.md
# Clock Divider Reset and Synchronization Controller

This block is the control side of a clock distribution section that drives several programmable output dividers. Software writes a small register bank through a plain write strobe, address and data interface and reads it back through a combinational read port. The bank holds one ratio register per divider, a control register with a sticky soft reset bit, and a function register. The function register sets the role of one multi-function pin and carries a soft sync bit.

The bank can be returned to its defaults in three ways. The first is a power-on reset. The second is the multi-function pin held low while it is configured as a reset. The third is the soft reset bit, which restores every register except the control register that holds it. The dividers can be frozen in two ways: by the multi-function pin held low while it is configured as a sync, or by the soft sync bit. While frozen, every counter is cleared and every output is held low. When the last sync source goes away, all counters restart on the same clock edge, so the outputs leave the freeze with a known phase relationship to each other.

Top module: `ckdist_ctrl`

## Requirements
- R1: After `rst`, the control register (address 00h) reads 00h, the function register (address 58h) reads 00h, the ratio register of divider i (address 40h+i) reads i+1, and every `div_out` bit is low.
- R2: A value written to a mapped address (00h, 58h, 40h+i) reads back unchanged at that address on the next cycle. A write to an unmapped address changes nothing, and any unmapped address reads 00h.
- R3: When function bits 6:5 are 00 (pin reset mode), `mf_pin_n` passes through a two-flop synchronizer. All registers, the control register included, return to their defaults on the third rising edge after the pin falls. Writes are ignored for as long as the synchronized pin stays low.
- R4: Control bit 5 is the soft reset. On each edge while it reads 1, every register other than the control register returns to its default, and writes to those registers are ignored. The control register keeps its value, bit 5 included, until software writes bit 5 to 0. Writes to the other registers then take effect again.
- R5: A running divider with ratio value v toggles its output every v+1 clocks. After a release, its first rising output edge comes v+1 edges after the first free-running edge, and its period is 2(v+1) clocks.
- R6: When function bits 6:5 are 01 (pin sync mode), a low synchronized `mf_pin_n` clears every counter and holds every output low, and leaves the registers unchanged. After release, all outputs restart on the same edge.
- R7: When function bit 2 is 1, all outputs are held low from the second rising edge after the write. Writing the bit to 0 releases all dividers on the same edge.
- R8: The freeze is the OR of the pin sync and the soft sync. Outputs stay held while either source is active. With function bits 6:5 at 10 or 11, `mf_pin_n` neither resets nor freezes anything.
- R9: While a soft reset or a pin reset is active, every divider output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank, the synchronizer and the divider counters |
| rst | input | 1 | Power-on reset, synchronous, active high |
| mf_pin_n | input | 1 | Multi-function pin, asynchronous, active low, used as a reset or as a sync depending on its mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data, combinational from `rd_addr` |
| div_out | output | NUM_DIV | Divider outputs, one bit per divider |

## Verification
The bench targets the latencies. If the synchronizer depth is counted wrong, the pin reset lands one edge early or late and the register read taken after the second edge shows the wrong value. If the soft reset clears the control register or clears itself, the control read-back loses bit 5. If it fails to block writes, a ratio register written during the reset reads back the written value instead of its default. In the release checks, a counter that restarts one edge late, or a divider that wakes before the others, shows up as a wrong bit pattern within the first three edges after release. Other cases catch designs that are wrong in other ways: a design that lets the pin act in modes 10 or 11 stops the running outputs, and one that releases on a single source while the other is still active lets the outputs run.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    // Register addresses
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] FUNC_ADDR = 8'h58;
    localparam logic [ADDR_W-1:0] DIV_BASE  = 8'h40;

    // Control register: bit position of the sticky soft reset
    localparam int SOFT_RST_BIT = 5;
    localparam logic [DATA_W-1:0] CTRL_DEFAULT = '0;

    // Role of the multi-function pin
    typedef enum logic [1:0] {
        PIN_HARD_RESET = 2'b00,
        PIN_SYNC_N     = 2'b01,
        PIN_UNUSED_A   = 2'b10,
        PIN_UNUSED_B   = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic       spare7;
        pin_mode_e  pin_mode;
        logic [1:0] spare4_3;
        logic       soft_sync;
        logic [1:0] spare1_0;
    } func_reg_t;

    localparam func_reg_t FUNC_DEFAULT = '{
        spare7:    1'b0,
        pin_mode:  PIN_HARD_RESET,
        spare4_3:  2'b00,
        soft_sync: 1'b0,
        spare1_0:  2'b00
    };

    // Sources that can freeze the dividers
    typedef struct packed {
        logic hard_rst;
        logic soft_rst;
        logic pin_sync;
        logic soft_sync;
    } ctl_req_t;

    function automatic logic [DATA_W-1:0] div_default(input int idx);
        return DATA_W'(idx + 1);
    endfunction

    function automatic logic hold_from(input ctl_req_t r);
        return |r;
    endfunction

endpackage

// File: rtl/ckd_sync2.sv
module ckd_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end

endmodule

// File: rtl/ckd_regbank.sv
module ckd_regbank
    import ckd_pkg::*;
#(
    parameter int NUM_DIV = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            hard_rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            soft_rst,
    output pin_mode_e                       pin_mode,
    output logic                            soft_sync,
    output logic [NUM_DIV-1:0][DATA_W-1:0]  div_ratio
);

    logic [DATA_W-1:0]              ctrl_q;
    func_reg_t                      func_q;
    logic [NUM_DIV-1:0][DATA_W-1:0] div_q;
    logic [NUM_DIV-1:0][DATA_W-1:0] div_def;
    logic                           soft_q;

    assign soft_q = ctrl_q[SOFT_RST_BIT];

    always_comb begin
        for (int i = 0; i < NUM_DIV; i++) begin
            div_def[i] = div_default(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hard_rst) begin
            ctrl_q <= CTRL_DEFAULT;
            func_q <= FUNC_DEFAULT;
            div_q  <= div_def;
        end else begin
            if (wr_en && wr_addr == CTRL_ADDR) begin
                ctrl_q <= wr_data;
            end
            if (soft_q) begin
                func_q <= FUNC_DEFAULT;
                div_q  <= div_def;
            end else if (wr_en) begin
                if (wr_addr == FUNC_ADDR) begin
                    func_q <= func_reg_t'(wr_data);
                end
                for (int i = 0; i < NUM_DIV; i++) begin
                    if (wr_addr == DIV_BASE + ADDR_W'(i)) begin
                        div_q[i] <= wr_data;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) rd_data = ctrl_q;
        if (rd_addr == FUNC_ADDR) rd_data = func_q;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (rd_addr == DIV_BASE + ADDR_W'(i)) rd_data = div_q[i];
        end
    end

    assign soft_rst  = soft_q;
    assign pin_mode  = func_q.pin_mode;
    assign soft_sync = func_q.soft_sync;
    assign div_ratio = div_q;

    // R4: a pending soft reset puts the other registers back to default
    assert_soft_restores_R4: assert property (@(posedge clk) disable iff (rst)
        (soft_q && !hard_rst) |=> (func_q == FUNC_DEFAULT && div_q == div_def));

    // R3: a pin reset puts the control and function registers back to default
    assert_hard_defaults_R3: assert property (@(posedge clk) disable iff (rst)
        hard_rst |=> (ctrl_q == CTRL_DEFAULT && func_q == FUNC_DEFAULT));

    // R4: the soft reset bit stays set unless the control register is written
    assert_soft_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (soft_q && !hard_rst && !(wr_en && wr_addr == CTRL_ADDR)) |=> soft_q);

endmodule

// File: rtl/ckd_divider.sv
module ckd_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] ratio,
    output logic         clk_out
);

    logic [W-1:0] cnt_q;
    logic         out_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (cnt_q >= ratio) begin
            cnt_q <= '0;
            out_q <= ~out_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clk_out = out_q;

    // R5: the output only changes at the terminal count
    assert_no_early_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (!hold && cnt_q < ratio) |=> $stable(out_q));

    // R6: a freeze leaves the counter at zero
    assert_hold_clears_count_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt_q == '0));

endmodule

// File: rtl/ckdist_ctrl.sv
module ckdist_ctrl
    import ckd_pkg::*;
#(
    parameter int NUM_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mf_pin_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_DIV-1:0] div_out
);

    logic                           pin_s;
    logic                           soft_rst;
    pin_mode_e                      pin_mode;
    logic                           soft_sync;
    logic [NUM_DIV-1:0][DATA_W-1:0] div_ratio;
    ctl_req_t                       req;
    logic                           hold;

    ckd_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (mf_pin_n),
        .q   (pin_s)
    );

    always_comb begin
        req.hard_rst  = (pin_mode == PIN_HARD_RESET) && !pin_s;
        req.pin_sync  = (pin_mode == PIN_SYNC_N) && !pin_s;
        req.soft_rst  = soft_rst;
        req.soft_sync = soft_sync;
        hold          = hold_from(req);
    end

    ckd_regbank #(.NUM_DIV(NUM_DIV)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .hard_rst  (req.hard_rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .soft_rst  (soft_rst),
        .pin_mode  (pin_mode),
        .soft_sync (soft_sync),
        .div_ratio (div_ratio)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        ckd_divider #(.W(DATA_W)) u_div (
            .clk     (clk),
            .rst     (rst),
            .hold    (hold),
            .ratio   (div_ratio[g]),
            .clk_out (div_out[g])
        );
    end

    // R7 and R9: any active freeze source drives every output low
    assert_hold_outputs_low_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (div_out == '0));

    // R8: with the pin in an unused mode it freezes nothing on its own
    assert_pin_idle_modes_R8: assert property (@(posedge clk) disable iff (rst)
        (pin_mode[1] && !pin_s) |-> !(req.hard_rst || req.pin_sync));

endmodule

// File: tb/sim_ckdist_ctrl.sv
module sim_ckdist_ctrl;

    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_addr = '0;
    wire  [7:0]    rd_data;
    wire  [ND-1:0] div_out;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ckdist_ctrl #(.NUM_DIV(ND)) u0 (
        .clk      (clk),
        .rst      (rst),
        .mf_pin_n (pin_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .div_out  (div_out)
    );

    // Behavioural reference
    logic [7:0]    m_ctrl, m_func;
    logic [7:0]    m_div [ND];
    int            m_cnt [ND];
    logic [ND-1:0] m_out;
    logic          m_p1, m_p2;
    bit            m_hard, m_soft, m_hold;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return m_ctrl;
        if (a == 8'h58) return m_func;
        for (int i = 0; i < ND; i++) if (a == 8'h40 + 8'(i)) return m_div[i];
        return 8'h00;
    endfunction

    task automatic m_defaults();
        m_func = 8'h00;
        for (int i = 0; i < ND; i++) m_div[i] = 8'(i + 1);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 8'h00;
            m_defaults();
            for (int i = 0; i < ND; i++) m_cnt[i] = 0;
            m_out = '0;
            m_p1 = 1'b1;
            m_p2 = 1'b1;
        end else begin
            m_hard = (m_func[6:5] == 2'b00) && !m_p2;
            m_soft = m_ctrl[5];
            m_hold = m_hard || m_soft || m_func[2] || ((m_func[6:5] == 2'b01) && !m_p2);
            for (int i = 0; i < ND; i++) begin
                if (m_hold) begin
                    m_cnt[i] = 0;
                    m_out[i] = 1'b0;
                end else if (m_cnt[i] >= int'(m_div[i])) begin
                    m_cnt[i] = 0;
                    m_out[i] = ~m_out[i];
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (m_hard) begin
                m_ctrl = 8'h00;
                m_defaults();
            end else begin
                if (wr_en && wr_addr == 8'h00) m_ctrl = wr_data;
                if (m_soft) m_defaults();
                else if (wr_en) begin
                    if (wr_addr == 8'h58) m_func = wr_data;
                    for (int i = 0; i < ND; i++)
                        if (wr_addr == 8'h40 + 8'(i)) m_div[i] = wr_data;
                end
            end
            m_p2 = m_p1;
            m_p1 = pin_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(posedge clk) begin
        #5;
        if (cmp_on && !done) begin
            chk("R5 R6 R7 div_out vs model", 32'(div_out), 32'(m_out));
            chk("R2 R3 R4 rd_data vs model", 32'(rd_data), 32'(m_read(rd_addr)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1 reset state
        peek("R1 ctrl", 8'h00, 8'h00);
        peek("R1 func", 8'h58, 8'h00);
        for (int i = 0; i < ND; i++) peek("R1 ratio", 8'h40 + 8'(i), 8'(i + 1));
        chk("R1 div_out", 32'(div_out), 32'h0);
        // R2 read-back and unmapped addresses
        wr(8'h40, 8'h00);
        wr(8'h41, 8'h02);
        peek("R2 ratio0", 8'h40, 8'h00);
        peek("R2 ratio1", 8'h41, 8'h02);
        wr(8'h10, 8'hAA);
        peek("R2 unmapped", 8'h10, 8'h00);
        // R7 soft sync freeze and aligned release, R5 toggle timing
        wr(8'h58, 8'h04);
        idle(1);
        chk("R7 held low", 32'(div_out), 32'h0);
        wr(8'h58, 8'h00);
        chk("R7 still low at release edge", 32'(div_out), 32'h0);
        idle(1);
        chk("R5 first edge", 32'(div_out), 32'h1);
        idle(1);
        chk("R5 second edge", 32'(div_out), 32'h0);
        idle(1);
        chk("R5 third edge", 32'(div_out), 32'h3);
        // R6 pin sync mode
        wr(8'h58, 8'h20);
        pin_n = 1'b0;
        idle(3);
        chk("R6 pin hold", 32'(div_out), 32'h0);
        peek("R6 regs untouched", 8'h41, 8'h02);
        peek("R6 func untouched", 8'h58, 8'h20);
        // R8 both sources, pin released first
        wr(8'h58, 8'h24);
        pin_n = 1'b1;
        idle(5);
        chk("R8 soft source still holds", 32'(div_out), 32'h0);
        wr(8'h58, 8'h20);
        idle(1);
        chk("R6 release together", 32'(div_out), 32'h1);
        // R8 unused pin mode
        wr(8'h58, 8'h40);
        pin_n = 1'b0;
        idle(4);
        peek("R8 idle mode func", 8'h58, 8'h40);
        peek("R8 idle mode ratio", 8'h41, 8'h02);
        pin_n = 1'b1;
        idle(3);
        // R4 soft reset
        wr(8'h00, 8'h21);
        idle(1);
        peek("R4 ctrl kept", 8'h00, 8'h21);
        peek("R4 func default", 8'h58, 8'h00);
        peek("R4 ratio0 default", 8'h40, 8'h01);
        chk("R9 soft reset holds", 32'(div_out), 32'h0);
        wr(8'h42, 8'h77);
        peek("R4 write ignored", 8'h42, 8'h03);
        idle(5);
        peek("R4 not self clearing", 8'h00, 8'h21);
        wr(8'h00, 8'h00);
        wr(8'h42, 8'h07);
        peek("R4 writes resume", 8'h42, 8'h07);
        // R3 pin reset
        wr(8'h00, 8'h03);
        pin_n = 1'b0;
        idle(2);
        peek("R3 not before third edge", 8'h00, 8'h03);
        idle(1);
        peek("R3 ctrl default", 8'h00, 8'h00);
        peek("R3 ratio default", 8'h42, 8'h03);
        wr(8'h42, 8'h55);
        peek("R3 write ignored", 8'h42, 8'h03);
        chk("R9 hard reset holds", 32'(div_out), 32'h0);
        pin_n = 1'b1;
        idle(4);
        peek("R3 defaults persist", 8'h42, 8'h03);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule